// File: doc/BRIEF.md
# Stack and Branch Sequencer

This unit is the control-flow and stack engine of a small 32-bit processor. It owns the program counter and the stack pointer. It carries out seven operations: push, pop, call, return, unconditional jump, conditional jump and conditional set. An external decoder pulses `start` with an operation code, a condition selector, the current flag bits, an operand word and the address of the following instruction. The unit runs the operation and answers with a one-cycle `done`.

Stack traffic goes through a word-wide memory port. The port has an address, write data and a write enable. Read data arrives one cycle after the address is presented. The stack grows toward low addresses and the pointer moves in steps of one word (4 bytes). Pop results and conditional-set results leave on a result bus, strobed by `res_we`. The flag `res_low_byte` marks a result meant only for the destination's low byte.

Top module: `stack_branch_seq`

## Requirements
- R1: After reset, `pc` is 0, `sp` is 0xFFFFFFFC (parameter `SP_INIT`), and `done`, `res_we` and `mem_we` are low.
- R2: Push (op 0) first lowers `sp` by 4. In the next cycle it writes `src` at the lowered address. `done` rises 2 cycles after the start edge, and `pc` is unchanged.
- R3: Pop (op 1) presents the current `sp` as a read address. It then returns that word on `res_data` with `res_we`=1 and `res_low_byte`=0, and raises `sp` by 4. All of this happens together with `done`, 3 cycles after the start edge.
- R4: Call (op 2) lowers `sp` by 4 and writes `next_pc` at the new address. It then loads `pc` with `src`, with `done` after 2 cycles.
- R5: Return (op 3) reads the word at `sp` into `pc` and raises `sp` by 4, with `done` after 3 cycles and no `res_we`.
- R6: Jump (op 4) loads `pc` with `src` in one cycle.
- R7: Conditional jump (op 5) loads `pc` with `src` if the selected condition holds, and with `next_pc` otherwise. It takes one cycle.
- R8: Condition selector `cc` codes: 0 equal (ZF), 1 not equal (!ZF), 2 signed less (SF!=OF), 3 signed greater-or-equal (SF==OF), 4 signed less-or-equal ((SF!=OF)|ZF), 5 signed greater (negation of code 4), 6 zero (ZF), 7 not zero (!ZF).
- R9: Conditional set (op 6) returns 1 or 0 (the condition) on `res_data`, all other bits 0, with `res_we`=1 and `res_low_byte`=1. It takes one cycle, and `pc` and `sp` are unchanged.
- R10: Every operation raises `done` for exactly one cycle. A `start` that arrives while an operation is in progress is ignored. Op 7 only returns `done`.
- R11: The stack pointer's low two bits never change, and `sp` wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code |
| cc | input | 3 | Condition selector |
| fl_of | input | 1 | Overflow flag |
| fl_sf | input | 1 | Sign flag |
| fl_zf | input | 1 | Zero flag |
| src | input | W | Push value or branch target |
| next_pc | input | W | Address of the following instruction |
| mem_addr | output | W | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | W | Memory read data, one cycle after address |
| pc | output | W | Program counter |
| sp | output | W | Stack pointer |
| done | output | 1 | Operation finished (one cycle) |
| res_we | output | 1 | Result valid strobe |
| res_low_byte | output | 1 | Result targets only the low byte |
| res_data | output | W | Pop or conditional-set result |

## Verification
The bench builds the block with its default parameters: W of 32 and the stack pointer starting at 0xFFFFFFFC. Because the pointer starts at the top of the address space, a pop straight after reset wraps it to zero, so wrap-around is reached without extra setup. A full sweep of all 64 selector and flag combinations covers the condition table. Random sequences of operations, with deep call and push chains, check the ordering of pointer updates against memory traffic. The ignored-start case is exercised by issuing a jump during a pop in progress.

// File: rtl/stack_branch_seq.sv
module stack_branch_seq #(
  parameter int W = 32,
  parameter logic [W-1:0] SP_INIT = {{(W-2){1'b1}}, 2'b00}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [2:0]   cc,
  input  logic         fl_of,
  input  logic         fl_sf,
  input  logic         fl_zf,
  input  logic [W-1:0] src,
  input  logic [W-1:0] next_pc,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic         done,
  output logic         res_we,
  output logic         res_low_byte,
  output logic [W-1:0] res_data
);
  localparam logic [W-1:0] STEP = W'(W / 8);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_CALL = 3'd2, OP_RET = 3'd3,
                         OP_JMP = 3'd4, OP_JCC = 3'd5, OP_SETB = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_WT} state_t;
  state_t state;
  logic [2:0]   op_q;
  logic [W-1:0] wd_q, tgt_q;
  logic         lt, hold;

  assign lt = fl_sf ^ fl_of;
  always_comb begin
    case (cc)
      3'd0, 3'd6: hold = fl_zf;
      3'd1, 3'd7: hold = !fl_zf;
      3'd2:       hold = lt;
      3'd3:       hold = !lt;
      3'd4:       hold = lt | fl_zf;
      default:    hold = !(lt | fl_zf);
    endcase
  end

  assign mem_addr  = sp;
  assign mem_wdata = wd_q;
  assign mem_we    = (state == S_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q <= '0;
      wd_q <= '0;
      tgt_q <= '0;
      pc <= '0;
      sp <= SP_INIT;
      done <= 1'b0;
      res_we <= 1'b0;
      res_low_byte <= 1'b0;
      res_data <= '0;
    end else begin
      done <= 1'b0;
      res_we <= 1'b0;
      res_low_byte <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q <= op;
          case (op)
            OP_PUSH: begin
              sp <= sp - STEP;
              wd_q <= src;
              state <= S_WR;
            end
            OP_CALL: begin
              sp <= sp - STEP;
              wd_q <= next_pc;
              tgt_q <= src;
              state <= S_WR;
            end
            OP_POP, OP_RET: state <= S_RD;
            OP_JMP: begin
              pc <= src;
              done <= 1'b1;
            end
            OP_JCC: begin
              pc <= hold ? src : next_pc;
              done <= 1'b1;
            end
            OP_SETB: begin
              res_data <= {{(W-1){1'b0}}, hold};
              res_we <= 1'b1;
              res_low_byte <= 1'b1;
              done <= 1'b1;
            end
            default: done <= 1'b1;
          endcase
        end
        S_WR: begin
          if (op_q == OP_CALL) pc <= tgt_q;
          done <= 1'b1;
          state <= S_IDLE;
        end
        S_RD: state <= S_WT;
        default: begin
          if (op_q == OP_RET) pc <= mem_rdata;
          else begin
            res_data <= mem_rdata;
            res_we <= 1'b1;
          end
          sp <= sp + STEP;
          done <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // R2 / R4: the store lands at a pointer already lowered one cycle before
  a_r2_store_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> sp == $past(sp) - STEP);
  // R3: a popped result comes with the raised pointer
  a_r3_pop_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && !res_low_byte) |-> sp == $past(sp) + STEP);
  // R9: conditional set carries a single bit
  a_r9_setb_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && res_low_byte) |-> res_data[W-1:1] == '0);
  // R11: pointer stays word aligned
  a_r11_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sp[1:0]));
  // R10: the program counter only moves when an operation completes
  a_r10_pc_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc));
endmodule

// File: tb/test_stack_branch_seq.sv
module test_stack_branch_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0, cc = 0;
  logic fl_of = 0, fl_sf = 0, fl_zf = 0;
  logic [31:0] src = 0, next_pc = 0, mem_rdata = 0;
  logic [31:0] mem_addr, mem_wdata, pc, sp, res_data;
  logic mem_we, done, res_we, res_low_byte;
  int total = 0, bad = 0, wr_cnt = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  stack_branch_seq i_stack_branch_seq (.*);

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (32'hA5A50000 ^ a);
  endfunction

  always @(posedge clk) begin
    mem_rdata <= rd(mem_addr);
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_cnt++;
      wr_addr = mem_addr;
      wr_data = mem_wdata;
    end
  end

  function automatic bit cond(logic [2:0] c, logic o, logic s, logic z);
    case (c)
      0, 6: return z;
      1, 7: return !z;
      2: return s != o;
      3: return s == o;
      4: return (s != o) || z;
      default: return !((s != o) || z);
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int lat;
  logic [31:0] m_pc, m_sp;

  task automatic run(logic [2:0] o, logic [2:0] c, logic [31:0] s, logic [31:0] n);
    @(negedge clk);
    op = o; cc = c; src = s; next_pc = n; start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic after_done(string req);
    @(negedge clk);
    chk(done == 0, req, {31'b0, done}, 0);
  endtask

  task automatic do_op(logic [2:0] o, logic [2:0] c, logic [31:0] s, logic [31:0] n);
    int w0;
    logic [31:0] top, exp_sp;
    bit h;
    w0 = wr_cnt;
    top = rd(m_sp);
    h = cond(c, fl_of, fl_sf, fl_zf);
    run(o, c, s, n);
    case (o)
      0, 2: begin
        exp_sp = m_sp - 4;
        chk(lat == 2, o == 0 ? "R2 latency" : "R4 latency", lat, 2);
        chk(sp == exp_sp, o == 0 ? "R2 sp" : "R4 sp", sp, exp_sp);
        chk(wr_cnt == w0 + 1 && wr_addr == exp_sp, "R2 store addr", wr_addr, exp_sp);
        chk(wr_data == (o == 0 ? s : n), o == 0 ? "R2 data" : "R4 return addr", wr_data, o == 0 ? s : n);
        if (o == 2) m_pc = s;
        m_sp = exp_sp;
      end
      1: begin
        chk(lat == 3, "R3 latency", lat, 3);
        chk(res_we && !res_low_byte && res_data == top, "R3 result", res_data, top);
        m_sp = m_sp + 4;
      end
      3: begin
        chk(lat == 3 && !res_we, "R5 latency", lat, 3);
        m_pc = top;
        m_sp = m_sp + 4;
      end
      4: begin
        chk(lat == 1, "R6 latency", lat, 1);
        m_pc = s;
      end
      5: begin
        chk(lat == 1, "R7 latency", lat, 1);
        m_pc = h ? s : n;
      end
      6: begin
        chk(lat == 1 && res_we && res_low_byte, "R9 strobe", {res_we, res_low_byte}, 2'b11);
        chk(res_data == {31'b0, h}, "R9 value", res_data, {31'b0, h});
      end
      default: chk(lat == 1, "R10 op7", lat, 1);
    endcase
    if (o != 0 && o != 2) chk(wr_cnt == w0, "R10 no store", wr_cnt, w0);
    chk(pc == m_pc, "R7 pc", pc, m_pc);
    chk(sp == m_sp, "R11 sp", sp, m_sp);
    after_done("R10 single done");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(pc == 0, "R1 pc", pc, 0);
    chk(sp == 32'hFFFFFFFC, "R1 sp", sp, 32'hFFFFFFFC);
    chk(!done && !res_we && !mem_we, "R1 strobes", {done, res_we, mem_we}, 0);
    rst_n = 1;
    m_pc = 0;
    m_sp = 32'hFFFFFFFC;
    // R11: pop straight from reset wraps the pointer through zero
    do_op(1, 0, 0, 0);
    chk(sp == 0, "R11 wrap", sp, 0);
    do_op(0, 0, 32'h1111_2222, 0);
    // R8: every selector against every flag pattern
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 8; f++) begin
        {fl_of, fl_sf, fl_zf} = f[2:0];
        do_op(6, c[2:0], 0, 0);
        do_op(5, c[2:0], 32'h4000_0000 + c * 64 + f * 4, 32'h0000_1000 + f);
        chk(pc == (cond(c[2:0], f[2], f[1], f[0]) ? 32'h4000_0000 + c * 64 + f * 4 : 32'h1000 + f),
            "R8 table", pc, m_pc);
      end
    // R4 / R5: nested calls and returns
    do_op(2, 0, 32'h0000_2000, 32'h0000_0104);
    do_op(2, 0, 32'h0000_3000, 32'h0000_2008);
    do_op(3, 0, 0, 0);
    chk(pc == 32'h2008, "R5 inner return", pc, 32'h2008);
    do_op(3, 0, 0, 0);
    chk(pc == 32'h0104, "R5 outer return", pc, 32'h0104);
    do_op(4, 0, 32'hDEAD_BEE0, 0);
    do_op(7, 0, 32'h1234_5678, 0);
    // R10: a jump offered during a pop is ignored
    begin
      logic [31:0] top, pc0;
      int dn;
      pc0 = m_pc;
      top = rd(m_sp);
      @(negedge clk);
      op = 1; start = 1;
      @(negedge clk);
      op = 4; src = 32'h0BAD_0000;
      @(negedge clk);
      start = 0;
      dn = 0;
      repeat (4) begin
        if (done) dn++;
        @(negedge clk);
      end
      m_sp = m_sp + 4;
      chk(dn == 1, "R10 one done", dn, 1);
      chk(pc == pc0, "R10 busy start ignored", pc, pc0);
      chk(res_data == top && sp == m_sp, "R10 pop intact", res_data, top);
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      {fl_of, fl_sf, fl_zf} = 3'($urandom);
      do_op(o, 3'($urandom), $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule